// File: doc/BRIEF.md
# PWM Sequence Value Decoder

This block sits between a half-word memory and a four-channel pulse generator. When a start pulse arrives it captures a playback setup:

- the pointer and length of a sequence of 16-bit values;
- a load mode;
- a step mode;
- a refresh count;
- an end delay;
- a default counter top.

It then reads the values and spreads them onto the four channel compare outputs. In one load mode it also takes the counter top from the sequence.

The pulse generator reports the end of each of its periods with `period_end`. New values are applied only on such a boundary, except the very first step, which is applied as soon as it has been read. Each value can stay for one period plus a number of extra refresh periods, or it can advance only on an external `next_step` trigger. After the last value there is an optional hold time counted in periods. The block then reports completion. The block reads the next step while the current one is playing, so the update at a boundary takes no extra cycles.

Top module: `pwm_seq_decoder`

## Requirements
- R1: Load mode 0 (common) consumes one half-word per step and drives it onto all four channels.
- R2: Load mode 1 (grouped) consumes two half-words per step. The first drives channels 0 and 1, and the second drives channels 2 and 3.
- R3: Load mode 2 (individual) consumes four half-words per step, driving channels 0, 1, 2 and 3 in that order.
- R4: Load mode 3 (waveform) consumes four half-words per step. The first three drive channels 0 to 2 and channel 3 is driven 0. The low 15 bits of the fourth half-word become `top_out`. In modes 0 to 2, `top_out` is the `cfg_top` value captured at start.
- R5: Reads go to consecutive addresses starting at `cfg_ptr`, one address per cycle of `mem_rd_en`. Read data is taken one cycle after the request.
- R6: In automatic step mode (`cfg_trig`=0), each value is shown for 1 + refresh periods and is replaced at the `period_end` that closes the last of them. Every update pulses `load_strobe` once.
- R7: In triggered step mode (`cfg_trig`=1), the value advances at the first `period_end` at or after a `next_step` pulse; a trigger in the same cycle as `period_end` counts for that boundary. A trigger on the last value ends playback at that boundary. Refresh and end delay are ignored.
- R8: In automatic mode, `done` pulses and `busy` falls after the last value's periods plus `cfg_delay` more periods.
- R9: `seq_end` pulses exactly once per playback, after the final half-word of the last complete step has been read.
- R10: Half-words left over after the last complete step are never read. A length shorter than one step gives an immediate `done` with no update and no `seq_end`.
- R11: A start pulse while `busy` is high is ignored and does not change the playback in progress.
- R12: After reset all outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Start pulse; captures the setup inputs |
| cfg_ptr | input | AW | First half-word address |
| cfg_len | input | LW | Sequence length in half-words |
| cfg_mode | input | 2 | Load mode 0..3 |
| cfg_trig | input | 1 | 1 = triggered step mode |
| cfg_refresh | input | RW | Extra periods per value |
| cfg_delay | input | RW | Hold periods after last value |
| cfg_top | input | DW-1 | Counter top used outside waveform mode |
| period_end | input | 1 | End-of-period pulse from the pulse generator |
| next_step | input | 1 | Step trigger |
| mem_rd_en | output | 1 | Memory read request |
| mem_addr | output | AW | Memory read address |
| mem_rdata | input | DW | Read data, one cycle after request |
| cmp_out | output | 4*DW | Channel compare values, channel i at bits i*DW |
| top_out | output | DW-1 | Counter top for the pulse generator |
| load_strobe | output | 1 | Pulses when new values are presented |
| seq_end | output | 1 | Last step read |
| done | output | 1 | Playback finished |
| busy | output | 1 | Playback in progress |

## Verification
In triggered mode, the step trigger and the period boundary may arrive in the same cycle. One triggered run places every `next_step` pulse exactly on a `period_end` cycle. The scoreboard then expects every update exactly one period after the previous one, so a decoder that postponed a coincident trigger to the following boundary would show two. A second triggered run places its triggers inside the period, which confirms the ordinary case gives the same count.

// File: rtl/pwm_seq_decoder.sv
module pwm_seq_decoder #(
  parameter int DW = 16,
  parameter int AW = 16,
  parameter int LW = 16,
  parameter int RW = 16
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            start,
  input  logic [AW-1:0]   cfg_ptr,
  input  logic [LW-1:0]   cfg_len,
  input  logic [1:0]      cfg_mode,
  input  logic            cfg_trig,
  input  logic [RW-1:0]   cfg_refresh,
  input  logic [RW-1:0]   cfg_delay,
  input  logic [DW-2:0]   cfg_top,
  input  logic            period_end,
  input  logic            next_step,
  output logic            mem_rd_en,
  output logic [AW-1:0]   mem_addr,
  input  logic [DW-1:0]   mem_rdata,
  output logic [4*DW-1:0] cmp_out,
  output logic [DW-2:0]   top_out,
  output logic            load_strobe,
  output logic            seq_end,
  output logic            done,
  output logic            busy
);
  localparam int TW = DW - 1;

  function automatic logic [2:0] step_size(input logic [1:0] m);
    case (m)
      2'd0:    return 3'd1;
      2'd1:    return 3'd2;
      default: return 3'd4;
    endcase
  endfunction

  logic [1:0]    mode;
  logic          trig;
  logic [RW-1:0] refresh, delay;
  logic [TW-1:0] base_top;
  logic [AW-1:0] rd_addr;
  logic [LW-1:0] rem;
  logic          f_on, cap_on;
  logic [1:0]    f_idx, cap_idx;
  logic [DW-1:0] stage [4];
  logic          staged, stage_last, have_cur, cur_last;
  logic          adv_pend, trig_pend, in_delay;
  logic [RW-1:0] per_cnt, dly_cnt;

  wire [2:0]    k      = step_size(mode);
  wire [2:0]    k_new  = step_size(cfg_mode);
  wire [LW-1:0] k_l    = LW'(k);
  wire [1:0]    k_last = 2'(k - 3'd1);

  assign mem_rd_en = f_on;
  assign mem_addr  = rd_addr;

  wire playing    = busy && have_cur && !in_delay;
  wire val_over   = playing && period_end &&
                    (trig ? (trig_pend || next_step) : (per_cnt == refresh));
  wire finish_val = val_over && cur_last;
  wire apply      = staged && (!have_cur || adv_pend || (val_over && !cur_last));
  wire dly_over   = in_delay && period_end && (dly_cnt == delay - RW'(1));
  wire finish     = (finish_val && (trig || delay == '0)) || dly_over;

  logic [4*DW-1:0] dec_cmp;
  logic [TW-1:0]   dec_top;
  always_comb begin
    case (mode)
      2'd0:    dec_cmp = {stage[0], stage[0], stage[0], stage[0]};
      2'd1:    dec_cmp = {stage[1], stage[1], stage[0], stage[0]};
      2'd2:    dec_cmp = {stage[3], stage[2], stage[1], stage[0]};
      default: dec_cmp = {{DW{1'b0}}, stage[2], stage[1], stage[0]};
    endcase
    dec_top = (mode == 2'd3) ? stage[3][TW-1:0] : base_top;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode <= '0; trig <= 1'b0; refresh <= '0; delay <= '0; base_top <= '0;
      rd_addr <= '0; rem <= '0; f_on <= 1'b0; cap_on <= 1'b0;
      f_idx <= '0; cap_idx <= '0;
      for (int i = 0; i < 4; i++) stage[i] <= '0;
      staged <= 1'b0; stage_last <= 1'b0; have_cur <= 1'b0; cur_last <= 1'b0;
      adv_pend <= 1'b0; trig_pend <= 1'b0; in_delay <= 1'b0;
      per_cnt <= '0; dly_cnt <= '0;
      cmp_out <= '0; top_out <= '0;
      load_strobe <= 1'b0; seq_end <= 1'b0; done <= 1'b0; busy <= 1'b0;
    end else begin
      load_strobe <= 1'b0;
      seq_end     <= 1'b0;
      done        <= 1'b0;
      if (start && !busy) begin
        mode <= cfg_mode; trig <= cfg_trig; refresh <= cfg_refresh;
        delay <= cfg_delay; base_top <= cfg_top;
        staged <= 1'b0; have_cur <= 1'b0; cur_last <= 1'b0;
        adv_pend <= 1'b0; trig_pend <= 1'b0; in_delay <= 1'b0;
        cap_on <= 1'b0; per_cnt <= '0;
        if (cfg_len < LW'(k_new)) begin
          done <= 1'b1;
        end else begin
          busy    <= 1'b1;
          rd_addr <= cfg_ptr;
          rem     <= cfg_len - LW'(k_new);
          f_on    <= 1'b1;
          f_idx   <= '0;
        end
      end else if (busy) begin
        cap_on  <= f_on;
        cap_idx <= f_idx;
        if (f_on) begin
          rd_addr <= rd_addr + AW'(1);
          f_idx   <= f_idx + 2'd1;
          if (f_idx == k_last) f_on <= 1'b0;
        end
        if (cap_on) begin
          stage[cap_idx] <= mem_rdata;
          if (cap_idx == k_last) begin
            staged     <= 1'b1;
            stage_last <= rem < k_l;
            seq_end    <= rem < k_l;
          end
        end

        if (next_step && playing) trig_pend <= 1'b1;
        if (val_over) begin
          trig_pend <= 1'b0;
          per_cnt   <= '0;
        end else if (playing && period_end) begin
          per_cnt <= per_cnt + RW'(1);
        end
        if (val_over && !cur_last && !staged) adv_pend <= 1'b1;

        if (apply) begin
          cmp_out     <= dec_cmp;
          top_out     <= dec_top;
          load_strobe <= 1'b1;
          staged      <= 1'b0;
          adv_pend    <= 1'b0;
          trig_pend   <= 1'b0;
          per_cnt     <= '0;
          have_cur    <= 1'b1;
          cur_last    <= stage_last;
          if (!stage_last) begin
            f_on  <= 1'b1;
            f_idx <= '0;
            rem   <= rem - k_l;
          end
        end

        if (finish_val && !trig && delay != '0) begin
          in_delay <= 1'b1;
          dly_cnt  <= '0;
        end else if (in_delay && period_end) begin
          dly_cnt <= dly_cnt + RW'(1);
        end

        if (finish) begin
          done     <= 1'b1;
          busy     <= 1'b0;
          in_delay <= 1'b0;
          have_cur <= 1'b0;
        end
      end
    end
  end

  p_rd_only_busy_r5: assert property (@(posedge clk) disable iff (!rst_n)
    mem_rd_en |-> busy);
  p_addr_consecutive_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_rd_en && $past(mem_rd_en)) |-> mem_addr == $past(mem_addr) + AW'(1));
  p_load_in_run_r1: assert property (@(posedge clk) disable iff (!rst_n)
    load_strobe |-> busy);
  p_done_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);
  p_end_not_done_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !(seq_end && done));
  p_start_ignored_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (start && busy) |=> $stable(mode) && $stable(trig));
endmodule

// File: tb/pwm_seq_decoder_test.sv
`timescale 1ns/1ps
module pwm_seq_decoder_test;
  localparam int DW = 16, AW = 16, LW = 16, RW = 16, PER = 20;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic rst_n = 1'b0, start = 1'b0, cfg_trig = 1'b0, period_end = 1'b0, next_step = 1'b0;
  logic [AW-1:0] cfg_ptr = '0;
  logic [LW-1:0] cfg_len = '0;
  logic [1:0] cfg_mode = '0;
  logic [RW-1:0] cfg_refresh = '0, cfg_delay = '0;
  logic [DW-2:0] cfg_top = '0;
  logic mem_rd_en, load_strobe, seq_end, done, busy;
  logic [AW-1:0] mem_addr;
  logic [DW-1:0] mem_rdata = '0;
  logic [4*DW-1:0] cmp_out;
  logic [DW-2:0] top_out;

  pwm_seq_decoder #(.DW(DW), .AW(AW), .LW(LW), .RW(RW)) uut (
    .clk(clk), .rst_n(rst_n), .start(start), .cfg_ptr(cfg_ptr), .cfg_len(cfg_len),
    .cfg_mode(cfg_mode), .cfg_trig(cfg_trig), .cfg_refresh(cfg_refresh),
    .cfg_delay(cfg_delay), .cfg_top(cfg_top), .period_end(period_end),
    .next_step(next_step), .mem_rd_en(mem_rd_en), .mem_addr(mem_addr),
    .mem_rdata(mem_rdata), .cmp_out(cmp_out), .top_out(top_out),
    .load_strobe(load_strobe), .seq_end(seq_end), .done(done), .busy(busy));

  typedef struct {
    bit          is_done;
    logic [63:0] cmp;
    logic [14:0] top;
    int          periods;
    int          seqend;
    string       req;
  } exp_t;

  exp_t q[$];
  exp_t e_m;
  logic [15:0] mem [256];
  int checks = 0, fails = 0;
  bit trig_req = 0, align = 0, cur_trig = 0;
  int pc = 0, se_cnt = 0, gcnt = 0;
  int exp_addr = 0;

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  always @(posedge clk) if (mem_rd_en) mem_rdata <= mem[mem_addr[7:0]];

  // period generator and step trigger driver
  initial begin
    forever begin
      @(posedge clk); #1;
      period_end = rst_n && (gcnt == PER - 1);
      next_step = 1'b0;
      if (trig_req && (align ? period_end : !period_end)) begin
        next_step = 1'b1;
        trig_req = 0;
      end
      gcnt = (gcnt == PER - 1) ? 0 : gcnt + 1;
    end
  end

  // monitor / scoreboard
  always @(negedge clk) begin
    if (rst_n) begin
      if (mem_rd_en) begin
        chk(mem_addr == AW'(exp_addr), "R5", "read address", mem_addr, exp_addr);
        exp_addr++;
      end
      if (load_strobe || done) begin
        if (q.size() == 0) begin
          chk(0, "R11", "unexpected event", {load_strobe, done}, 0);
        end else begin
          e_m = q.pop_front();
          chk(done == e_m.is_done, e_m.req, "event kind", done, e_m.is_done);
          if (!e_m.is_done) begin
            chk(cmp_out == e_m.cmp, e_m.req, "compare values", cmp_out, e_m.cmp);
            chk(top_out == e_m.top, e_m.req, "counter top", top_out, e_m.top);
            if (cur_trig) trig_req = 1;
          end else begin
            chk(se_cnt == e_m.seqend, "R9", "sequence end pulses", se_cnt, e_m.seqend);
            se_cnt = 0;
          end
          if (e_m.periods >= 0)
            chk(pc == e_m.periods, e_m.req, "periods since update", pc, e_m.periods);
        end
        pc = 0;
      end
      if (seq_end) se_cnt++;
      if (period_end) pc++;
    end
  end

  function automatic logic [63:0] exp_cmp(input int mode, input int b);
    logic [15:0] v0, v1, v2, v3;
    v0 = mem[b]; v1 = mem[b+1]; v2 = mem[b+2]; v3 = mem[b+3];
    case (mode)
      0:       return {v0, v0, v0, v0};
      1:       return {v1, v1, v0, v0};
      2:       return {v3, v2, v1, v0};
      default: return {16'h0000, v2, v1, v0};
    endcase
  endfunction

  task automatic run(input int ptr, input int len, input int mode, input bit trig,
                     input int refresh, input int delay, input int top,
                     input bit al, input bit intrude);
    int k = (mode == 0) ? 1 : (mode == 1) ? 2 : 4;
    int steps = len / k;
    exp_t e;
    string rq = (mode == 0) ? "R1" : (mode == 1) ? "R2" : (mode == 2) ? "R3" : "R4";
    for (int s = 0; s < steps; s++) begin
      e.is_done = 0;
      e.cmp = exp_cmp(mode, ptr + s * k);
      e.top = (mode == 3) ? mem[ptr + s * k + 3][14:0] : 15'(top);
      e.periods = (s == 0) ? -1 : (trig ? 1 : 1 + refresh);
      e.seqend = 0;
      e.req = (s == 0) ? rq : (trig ? "R7" : "R6");
      q.push_back(e);
    end
    e.is_done = 1; e.cmp = '0; e.top = '0;
    e.periods = (steps == 0) ? -1 : (trig ? 1 : 1 + refresh + delay);
    e.seqend = (steps > 0) ? 1 : 0;
    e.req = (steps == 0) ? "R10" : (trig ? "R7" : "R8");
    q.push_back(e);
    @(posedge clk); #1;
    cur_trig = trig; align = al; exp_addr = ptr;
    cfg_ptr = AW'(ptr); cfg_len = LW'(len); cfg_mode = 2'(mode); cfg_trig = trig;
    cfg_refresh = RW'(refresh); cfg_delay = RW'(delay); cfg_top = 15'(top);
    start = 1'b1;
    @(posedge clk); #1;
    start = 1'b0;
    if (intrude) begin
      repeat (30) @(posedge clk);
      #1;
      cfg_ptr = AW'(200); cfg_mode = 2'd2; cfg_trig = 1'b1; cfg_len = LW'(8);
      start = 1'b1;
      @(posedge clk); #1;
      start = 1'b0;
    end
    while (q.size() != 0) @(posedge clk);
    @(negedge clk);
    chk(!busy, e.req, "busy after done", busy, 0);
    chk(exp_addr == ptr + steps * k, "R10", "half-words read", exp_addr, ptr + steps * k);
    cur_trig = 0;
    repeat (3) @(posedge clk);
  endtask

  initial begin
    for (int i = 0; i < 256; i++) mem[i] = 16'((i * 16'h0913 + 16'h0155) ^ (i << 11));
  end

  initial begin
    repeat (4) @(posedge clk);
    #1 rst_n = 1'b1;
    @(negedge clk);
    chk(cmp_out == '0 && top_out == '0, "R12", "reset outputs", cmp_out, 0);
    chk({mem_rd_en, load_strobe, seq_end, done, busy} == '0, "R12", "reset strobes",
        {mem_rd_en, load_strobe, seq_end, done, busy}, 0);
    run(0,   3, 0, 0, 1, 2, 15'h1234, 0, 0);
    run(10,  4, 1, 0, 0, 0, 15'h0222, 0, 0);
    run(20,  9, 2, 0, 2, 1, 15'h0333, 0, 0);
    run(40,  8, 3, 0, 0, 0, 15'h0444, 0, 0);
    run(60,  8, 2, 1, 5, 3, 15'h0555, 0, 0);
    run(80,  3, 0, 1, 0, 0, 15'h0666, 1, 0);
    run(100, 1, 1, 0, 0, 0, 15'h0777, 0, 0);
    run(120, 4, 0, 0, 1, 1, 15'h0888, 0, 1);
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule